// File: doc/BRIEF.md
# On/Off Threshold Backpressure Controller

This block sits on the receiving side of a link. It keeps track of how many entries of its input buffer are still free, and it tells the sender when to stop and when to resume. It does this with a single level signal that changes only when one of two watermarks is crossed, so it does not return a token for every flit. The stop level (low watermark) is below the resume level (high watermark). The gap between them gives hysteresis, which stops the signal from toggling every cycle when the buffer fill level hovers near one threshold.

The same top module also models the sending end and both wire directions. The control level travels upstream through a delay line of parameterized length. The sender issues at most one flit per cycle, and only while the most recent level it has received says "go". Each issued flit travels downstream through a second delay line and then takes a buffer entry. The downstream consumer frees entries with a pop strobe. When a flit lands while no entry is free, the flit is dropped and a sticky overflow flag is raised. The low watermark must leave room for every flit that is still on the wire when the stop level reaches the sender. The high watermark must let new flits arrive before the buffer drains.

Top module: `onoff_bp_ctrl`

## Requirements
- R1: After reset, free_cnt equals BUF_DEPTH, on_state and seen_on are 1, and signal_evt and overflow are 0.
- R2: An arriving flit lowers free_cnt by one and an accepted pop raises it by one, effective on the next cycle. When both occur in the same cycle, free_cnt is unchanged.
- R3: A pop while free_cnt equals BUF_DEPTH is ignored, and free_cnt never exceeds BUF_DEPTH.
- R4: While on_state is 1, a registered free_cnt below LOW_MARK drives on_state to 0 in the next cycle. Under a steady one-per-cycle fill, on_state is first seen at 0 with free_cnt equal to LOW_MARK-2.
- R5: While on_state is 0, a registered free_cnt above HIGH_MARK drives on_state to 1 in the next cycle. Under a steady one-per-cycle drain, on_state is first seen at 1 with free_cnt equal to HIGH_MARK+2.
- R6: While free_cnt lies between LOW_MARK and HIGH_MARK inclusive, on_state keeps its value.
- R7: signal_evt is high for exactly one cycle in each cycle in which on_state has just changed, and is low otherwise.
- R8: seen_on follows on_state delayed by CTRL_LAT cycles, and src_fire equals src_valid while seen_on is 1 and is 0 while seen_on is 0.
- R9: A flit issued in a cycle first lowers free_cnt FLIT_LAT+1 cycles later.
- R10: When LOW_MARK is at least CTRL_LAT+FLIT_LAT+2, overflow never rises. A continuous send from a full buffer with no pops stops with LOW_MARK-2-CTRL_LAT-FLIT_LAT entries free.
- R11: A flit arriving while free_cnt is 0 is dropped (free_cnt stays 0) and sets overflow. overflow then stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | Sender has a flit ready |
| src_fire | output | 1 | Sender issues a flit this cycle |
| sink_pop | input | 1 | Consumer frees one buffer entry |
| free_cnt | output | $clog2(BUF_DEPTH+1) | Registered number of free buffer entries |
| on_state | output | 1 | Receiver-side flow state, 1 = go, 0 = stop |
| seen_on | output | 1 | Flow state as received by the sender after the wire delay |
| signal_evt | output | 1 | One-cycle pulse when on_state has just changed |
| overflow | output | 1 | Sticky flag: a flit arrived with no free entry |

## Verification
On every cycle the assertions check several properties. on_state may change only after its watermark has been crossed, and it holds while free_cnt is in the band between the watermarks. signal_evt must line up with each change of state. free_cnt moves by at most one per cycle and stays within the depth, and overflow is sticky. For parameter sets that meet the safety margin, they also check that overflow never rises. The bench scenarios cover what needs a known history. These are the exact free counts at which the state flips under steady fill and drain, the residual free space after in-flight flits land, and the CTRL_LAT lag between on_state and seen_on. They also cover the FLIT_LAT+1 delay before an issued flit lands, and the dropping of a flit on a full buffer with an undersized low watermark.

// File: rtl/onoff_bp_pkg.sv
package onoff_bp_pkg;

   typedef enum logic {
      LS_STOP = 1'b0,
      LS_GO   = 1'b1
   } link_state_e;

   function automatic int cnt_width(input int depth);
      return $clog2(depth + 1);
   endfunction

endpackage

// File: rtl/onoff_delay_line.sv
module onoff_delay_line #(
   parameter int   WIDTH     = 1,
   parameter int   STAGES    = 1,
   parameter logic RESET_BIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES == 0) begin : g_wire
         assign d_out = d_in;
      end else begin : g_pipe
         logic [STAGES-1:0][WIDTH-1:0] pipe_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pipe_q <= {STAGES{{WIDTH{RESET_BIT}}}};
            end else begin
               pipe_q[0] <= d_in;
               for (int i = 1; i < STAGES; i++) begin
                  pipe_q[i] <= pipe_q[i-1];
               end
            end
         end

         assign d_out = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/onoff_free_tracker.sv
module onoff_free_tracker #(
   parameter int BUF_DEPTH = 16,
   parameter int CW        = $clog2(BUF_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flit_land,
   input  logic          pop_req,
   output logic [CW-1:0] free_q,
   output logic          ovf_q
);

   localparam logic [CW-1:0] FULL_FREE = CW'(BUF_DEPTH);

   logic pop_ok;
   logic land_ok;
   logic land_drop;

   // a pop is honoured only when some entry is occupied
   assign pop_ok    = pop_req && (free_q != FULL_FREE);
   assign land_ok   = flit_land && (free_q != '0);
   assign land_drop = flit_land && (free_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_q <= FULL_FREE;
         ovf_q  <= 1'b0;
      end else begin
         case ({pop_ok, land_ok})
            2'b10:   free_q <= free_q + 1'b1;
            2'b01:   free_q <= free_q - 1'b1;
            default: free_q <= free_q;
         endcase
         if (land_drop) begin
            ovf_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/onoff_hysteresis.sv
module onoff_hysteresis
   import onoff_bp_pkg::*;
#(
   parameter int BUF_DEPTH = 16,
   parameter int LOW_MARK  = 6,
   parameter int HIGH_MARK = 10,
   parameter int CW        = $clog2(BUF_DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] free_in,
   output link_state_e   state_q,
   output logic          evt_q
);

   localparam logic [CW-1:0] LOW_LVL  = CW'(LOW_MARK);
   localparam logic [CW-1:0] HIGH_LVL = CW'(HIGH_MARK);

   link_state_e state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LS_GO:   if (free_in < LOW_LVL)  state_d = LS_STOP;
         LS_STOP: if (free_in > HIGH_LVL) state_d = LS_GO;
         default: state_d = LS_GO;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LS_GO;
         evt_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         evt_q   <= (state_d != state_q);
      end
   end

endmodule

// File: rtl/onoff_bp_ctrl.sv
module onoff_bp_ctrl
   import onoff_bp_pkg::*;
#(
   parameter int BUF_DEPTH = 16,
   parameter int LOW_MARK  = 6,
   parameter int HIGH_MARK = 10,
   parameter int CTRL_LAT  = 2,
   parameter int FLIT_LAT  = 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           src_valid,
   output logic                           src_fire,
   input  logic                           sink_pop,
   output logic [$clog2(BUF_DEPTH+1)-1:0] free_cnt,
   output logic                           on_state,
   output logic                           seen_on,
   output logic                           signal_evt,
   output logic                           overflow
);

   localparam int CW = cnt_width(BUF_DEPTH);

   // elaboration-time parameter checks
   generate
      if (BUF_DEPTH < 2) begin : g_bad_depth
         $error("BUF_DEPTH must be at least 2");
      end
      if (LOW_MARK < 1) begin : g_bad_low
         $error("LOW_MARK must be at least 1");
      end
      if (HIGH_MARK <= LOW_MARK) begin : g_bad_order
         $error("HIGH_MARK must exceed LOW_MARK");
      end
      if (HIGH_MARK >= BUF_DEPTH) begin : g_bad_high
         $error("HIGH_MARK must be below BUF_DEPTH");
      end
      if (CTRL_LAT < 0 || FLIT_LAT < 0) begin : g_bad_lat
         $error("latencies must not be negative");
      end
   endgenerate

   link_state_e rx_state;
   logic        rx_go;
   logic        tx_go;
   logic        flit_land;
   logic        evt;
   logic        ovf;
   logic [CW-1:0] free_q;

   // sending end: one flit per cycle while the last seen level is go
   assign src_fire = src_valid && tx_go;

   onoff_delay_line #(
      .WIDTH     (1),
      .STAGES    (FLIT_LAT),
      .RESET_BIT (1'b0)
   ) u_flit_wire (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (src_fire),
      .d_out (flit_land)
   );

   onoff_free_tracker #(
      .BUF_DEPTH (BUF_DEPTH),
      .CW        (CW)
   ) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .flit_land (flit_land),
      .pop_req   (sink_pop),
      .free_q    (free_q),
      .ovf_q     (ovf)
   );

   onoff_hysteresis #(
      .BUF_DEPTH (BUF_DEPTH),
      .LOW_MARK  (LOW_MARK),
      .HIGH_MARK (HIGH_MARK),
      .CW        (CW)
   ) u_hyst (
      .clk     (clk),
      .rst_n   (rst_n),
      .free_in (free_q),
      .state_q (rx_state),
      .evt_q   (evt)
   );

   assign rx_go = (rx_state == LS_GO);

   onoff_delay_line #(
      .WIDTH     (1),
      .STAGES    (CTRL_LAT),
      .RESET_BIT (1'b1)
   ) u_ctrl_wire (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_go),
      .d_out (tx_go)
   );

   assign free_cnt   = free_q;
   assign on_state   = rx_go;
   assign seen_on    = tx_go;
   assign signal_evt = evt;
   assign overflow   = ovf;

endmodule

// File: rtl/onoff_bp_chk.sv
module onoff_bp_chk #(
   parameter int BUF_DEPTH = 16,
   parameter int LOW_MARK  = 6,
   parameter int HIGH_MARK = 10,
   parameter int CTRL_LAT  = 2,
   parameter int FLIT_LAT  = 1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [$clog2(BUF_DEPTH+1)-1:0] free_cnt,
   input logic                           on_state,
   input logic                           signal_evt,
   input logic                           overflow
);

   localparam int SAFE_LOW = CTRL_LAT + FLIT_LAT + 2;

   // R4
   stop_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(on_state) |-> ($past(free_cnt) < LOW_MARK));

   // R5
   go_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(on_state) |-> ($past(free_cnt) > HIGH_MARK));

   // R6
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_cnt >= LOW_MARK && free_cnt <= HIGH_MARK) |=> $stable(on_state));

   // R7
   evt_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(on_state) || $fell(on_state)) |-> signal_evt);

   // R7
   evt_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      signal_evt |-> ($rose(on_state) || $fell(on_state)));

   // R2
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (free_cnt == $past(free_cnt) ||
                free_cnt == $past(free_cnt) + 1'b1 ||
                free_cnt + 1'b1 == $past(free_cnt)));

   // R3
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      free_cnt <= BUF_DEPTH);

   // R11
   sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   generate
      if (LOW_MARK >= SAFE_LOW) begin : g_safe
         // R10
         no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !overflow);
      end
   endgenerate

endmodule

bind onoff_bp_ctrl onoff_bp_chk #(
   .BUF_DEPTH (BUF_DEPTH),
   .LOW_MARK  (LOW_MARK),
   .HIGH_MARK (HIGH_MARK),
   .CTRL_LAT  (CTRL_LAT),
   .FLIT_LAT  (FLIT_LAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .free_cnt   (free_cnt),
   .on_state   (on_state),
   .signal_evt (signal_evt),
   .overflow   (overflow)
);

// File: tb/tb_onoff_bp_ctrl.sv
`timescale 1ns/1ps
module tb_onoff_bp_ctrl;

   localparam int DEPTH = 16;
   localparam int LOWM  = 6;
   localparam int HIGHM = 10;
   localparam int CLAT  = 2;
   localparam int FLAT  = 1;
   localparam int REST  = LOWM - 2 - CLAT - FLAT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       src_valid = 1'b0, sink_pop = 1'b0;
   logic       src_fire, on_state, seen_on, signal_evt, overflow;
   logic [4:0] free_cnt;

   logic       t_valid = 1'b0, t_pop = 1'b0;
   logic       t_fire, t_on, t_seen, t_evt, t_ovf;
   logic [2:0] t_free;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   onoff_bp_ctrl #(.BUF_DEPTH(DEPTH), .LOW_MARK(LOWM), .HIGH_MARK(HIGHM),
                   .CTRL_LAT(CLAT), .FLIT_LAT(FLAT)) dut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_fire(src_fire),
      .sink_pop(sink_pop), .free_cnt(free_cnt), .on_state(on_state),
      .seen_on(seen_on), .signal_evt(signal_evt), .overflow(overflow));

   // undersized low watermark for the overflow scenario
   onoff_bp_ctrl #(.BUF_DEPTH(4), .LOW_MARK(1), .HIGH_MARK(2),
                   .CTRL_LAT(3), .FLIT_LAT(2)) dut_tight (
      .clk(clk), .rst_n(rst_n), .src_valid(t_valid), .src_fire(t_fire),
      .sink_pop(t_pop), .free_cnt(t_free), .on_state(t_on),
      .seen_on(t_seen), .signal_evt(t_evt), .overflow(t_ovf));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         src_valid = 1'b0;
         sink_pop  = 1'b0;
      end
      #1;
   endtask

   task automatic send_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         src_valid = 1'b1;
      end
      @(negedge clk);
      src_valid = 1'b0;
      idle(FLAT + 3);
   endtask

   task automatic pop_n(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sink_pop = 1'b1;
      end
      @(negedge clk);
      sink_pop = 1'b0;
      idle(2);
   endtask

   task automatic t_reset();
      #1;
      chk(free_cnt == DEPTH, "R1 free", free_cnt, DEPTH);
      chk(on_state && seen_on, "R1 state", {on_state, seen_on}, 3);
      chk(!signal_evt && !overflow, "R1 flags", {signal_evt, overflow}, 0);
      chk(t_free == 4 && !t_ovf, "R1 tight", t_free, 4);
   endtask

   // continuous send from full until the stop level throttles the sender
   task automatic t_fill();
      int fires = 0, evts = 0, fall_at = -1, seen_fall_at = -1, gate_bad = 0;
      bit prev_on = 1'b1, prev_seen = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         src_valid = 1'b1;
         #1;
         if (i == FLAT) chk(free_cnt == DEPTH, "R9 before land", free_cnt, DEPTH);
         if (i == FLAT + 1) chk(free_cnt == DEPTH - 1, "R9 land", free_cnt, DEPTH - 1);
         if (src_fire) fires++;
         if (src_fire != seen_on) gate_bad++;
         if (signal_evt) evts++;
         if (prev_on && !on_state) begin
            fall_at = i;
            chk(free_cnt == LOWM - 2, "R4 stop point", free_cnt, LOWM - 2);
         end
         if (prev_seen && !seen_on) seen_fall_at = i;
         prev_on = on_state;
         prev_seen = seen_on;
      end
      src_valid = 1'b0;
      idle(6);
      chk(seen_fall_at - fall_at == CLAT, "R8 lag", seen_fall_at - fall_at, CLAT);
      chk(gate_bad == 0, "R8 gate", gate_bad, 0);
      chk(evts == 1, "R7 one pulse on fill", evts, 1);
      chk(free_cnt == REST, "R10 residual", free_cnt, REST);
      chk(fires == DEPTH - REST, "R10 issued", fires, DEPTH - REST);
      chk(!overflow, "R10 no overflow", overflow, 0);
      chk(!on_state && !seen_on, "R4 stays stopped", on_state, 0);
   endtask

   // continuous drain from the stopped state, past full
   task automatic t_drain();
      int evts = 0, rises = 0;
      bit prev_on = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         sink_pop = 1'b1;
         #1;
         if (signal_evt) evts++;
         if (!prev_on && on_state) begin
            rises++;
            chk(free_cnt == HIGHM + 2, "R5 go point", free_cnt, HIGHM + 2);
         end
         prev_on = on_state;
      end
      sink_pop = 1'b0;
      idle(CLAT + 2);
      chk(rises == 1, "R5 single rise", rises, 1);
      chk(evts == 1, "R7 one pulse on drain", evts, 1);
      chk(free_cnt == DEPTH, "R3 pops at full ignored", free_cnt, DEPTH);
      chk(seen_on, "R8 sender resumes", seen_on, 1);
   endtask

   task automatic t_band();
      send_n(DEPTH - 8);
      chk(free_cnt == 8, "R2 count after sends", free_cnt, 8);
      chk(on_state, "R6 hold go in band", on_state, 1);
      pop_n(8);
      chk(free_cnt == DEPTH, "R2 count after pops", free_cnt, DEPTH);
      t_fill();
      pop_n(8 - REST);
      idle(4);
      chk(free_cnt == 8, "R2 count in band", free_cnt, 8);
      chk(!on_state && !seen_on, "R6 hold stop in band", on_state, 0);
      pop_n(DEPTH - 8);
      idle(CLAT + 2);
      chk(on_state && free_cnt == DEPTH, "R5 back to go", free_cnt, DEPTH);
   endtask

   task automatic t_both();
      send_n(6);
      chk(free_cnt == 10, "R2 preload", free_cnt, 10);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         src_valid = 1'b1;
         sink_pop  = 1'b1;
         #1;
         if (i == 2) chk(free_cnt == 11, "R2 arrive and pop together", free_cnt, 11);
      end
      idle(FLAT + 3);
      chk(free_cnt == 10, "R2 net zero", free_cnt, 10);
      chk(on_state && !overflow, "R2 state kept", on_state, 1);
      pop_n(6);
   endtask

   task automatic t_overflow();
      chk(!t_ovf, "R11 clear before flood", t_ovf, 0);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         t_valid = 1'b1;
      end
      @(negedge clk);
      t_valid = 1'b0;
      idle(8);
      chk(t_ovf, "R11 overflow raised", t_ovf, 1);
      chk(t_free == 0, "R11 dropped flit keeps zero", t_free, 0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         t_pop = 1'b1;
      end
      @(negedge clk);
      t_pop = 1'b0;
      idle(2);
      chk(t_free == 4, "R3 tight drained", t_free, 4);
      chk(t_ovf, "R11 sticky", t_ovf, 1);
   endtask

   task automatic t_rereset();
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      chk(!t_ovf && free_cnt == DEPTH, "R1 reset clears", t_ovf, 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fill();
      t_drain();
      t_band();
      t_both();
      t_overflow();
      t_rereset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule